// File: doc/BRIEF.md
# 16-bit Timer with Input Capture and Output Compare

The block is a free-running 16-bit counter with one input-capture channel, one output-compare channel and an overflow event, all reached through an 8-bit register bus. The counter advances once for every cycle in which the tick input is high. A capture copies the counter value into a capture register. The capture is triggered either by the selected edge on the capture pin, after a two-stage synchroniser, or by a one-cycle strobe from an internal comparator. A compare match drives the compare pin to a programmed level.

Each of the three events sets a status flag. A flag is cleared in two steps: a status read that sees the flag set arms it, and then a specific register access clears it. The flags, gated by their enables in the control register, are ORed into one interrupt request.

Software reads 16-bit values high byte first. Reading a high byte holds the matching low byte, so the pair is coherent. Software writes the compare value high byte first. Writing the high byte suspends matching until the low byte arrives, so a half-updated value cannot cause a false match.

Bus accesses are single-cycle. `bus_en_i` qualifies the access and `bus_we_i` selects a write. The side effects of an access happen at the rising clock edge. `bus_rdata_o` always shows the register selected by `bus_addr_i`.

Top module: `timer16_cc`

## Requirements
- R1: After reset the counter is 16'hFFFC, the status register reads 0, the compare pin and interrupt request are low, and the control register reads 0 except bit 1, which keeps its value from before the reset.
- R2: Each clock edge with tick_i high increments the counter, and an edge with tick_i low leaves it unchanged. The increment from 16'hFFFF to 16'h0000 sets the overflow flag.
- R3: Register addresses: 0 control, 1 status, 2 counter high, 3 counter low, 4 capture high, 5 capture low, 6 compare high, 7 compare low. In the control register, bit 7 enables the capture interrupt, bit 6 the compare interrupt and bit 5 the overflow interrupt. Bit 1 selects the capture edge (1 rising, 0 falling) and bit 0 is the compare output level. Bits 4 to 2 read 0.
- R4: The selected edge on cap_pin_i, applied before clock edge 1, sets the capture flag and loads the counter into the capture register at clock edge 3. The other edge has no effect.
- R5: A one-cycle pulse on cap_aux_i captures the counter and sets the capture flag at the next clock edge.
- R6: When a tick moves the counter onto the compare value, the compare flag is set and cmp_pin_o takes the control bit 0 value at that same edge.
- R7: A write to the compare high byte blocks matches, so neither the compare flag nor cmp_pin_o changes, until the compare low byte is written.
- R8: Status bit 7 is the capture flag, bit 6 the compare flag and bit 5 the overflow flag, and bits 4 to 0 read 0. A status read while a flag is set arms that flag. A compare low-byte write clears the compare flag only when the flag is armed.
- R9: An armed capture flag is cleared by a capture low-byte read. An armed overflow flag is cleared by a counter low-byte read. The same access without arming leaves the flag set.
- R10: irq_o is high exactly when some flag is set together with its enable bit.
- R11: A counter high-byte read holds the low byte. The next counter low-byte read returns the held value, and later low-byte reads return the live value.
- R12: A capture high-byte read holds the capture low byte. The next capture low-byte read returns it even if a capture occurred in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| cap_aux_i | input | 1 | Comparator capture strobe |
| cmp_pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes, ticks, compare matches and the comparator strobe all take effect at the first clock edge after the stimulus. The pin-capture path takes three edges: two synchroniser stages and then the capture register. The bench drives its inputs on the falling edge and samples on the falling edge that follows the edge where a result is due. For pin capture it samples after each of the three edges and checks that the flag is still clear after edges 1 and 2. The status register is observed by selecting its address without a bus strobe, so watching a flag never arms it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_CNT_HI = 3'd2;
  localparam logic [2:0] A_CNT_LO = 3'd3;
  localparam logic [2:0] A_CAP_HI = 3'd4;
  localparam logic [2:0] A_CAP_LO = 3'd5;
  localparam logic [2:0] A_CMP_HI = 3'd6;
  localparam logic [2:0] A_CMP_LO = 3'd7;

  // flag index i sits at status/enable bit (DATA_W-1-i)
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned F_CAP = 0;
  localparam int unsigned F_CMP = 1;
  localparam int unsigned F_OVF = 2;

  localparam int unsigned CTRL_EDGE_BIT = 1;
  localparam int unsigned CTRL_LVL_BIT  = 0;

  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned P_CNT = 0;
  localparam int unsigned P_CAP = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + CNT_W'(1);
  assign wrap_o     = tick_i && (cnt_q == '1);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (tick_i) cnt_q <= cnt_next_o;
  end

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(tick_i)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(tick_i)) |-> $stable(cnt_q));
  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wrap_o)) |-> (cnt_q == '0));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             aux_i,
  input  logic             rise_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] cap_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   edge_hit;
  logic [CNT_W-1:0]       cap_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_s;
  end

  assign edge_hit = rise_sel_i ? (pin_s & ~prev_q) : (~pin_s & prev_q);
  assign evt_o    = edge_hit | aux_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (evt_o) cap_q <= cnt_i;
  end
  assign cap_o = cap_q;

  assert_cap_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(evt_o)) |-> (cap_q == $past(cnt_i)));
  assert_cap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(evt_o)) |-> $stable(cap_q));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_next_i,
  input  logic              level_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_o,
  output logic              pin_o
);
  logic [DATA_W-1:0] hi_q, lo_q;
  logic              inhibit_q;
  logic              pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      lo_q      <= '0;
      inhibit_q <= 1'b0;
    end else begin
      if (wr_hi_i) begin
        hi_q      <= wdata_i;
        inhibit_q <= 1'b1;
      end
      if (wr_lo_i) begin
        lo_q      <= wdata_i;
        inhibit_q <= 1'b0;
      end
    end
  end

  assign cmp_o   = {hi_q, lo_q};
  assign match_o = tick_i && !inhibit_q && (cnt_next_i == cmp_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_q <= 1'b0;
    else if (match_o) pin_q <= level_i;
  end
  assign pin_o = pin_q;

  assert_pin_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(match_o)) |-> (pin_o == $past(level_i)));
  assert_inhibit_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(inhibit_q)) |-> $stable(pin_o));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (clr_i && arm_q) begin
      flag_q <= set_i;  // a fresh event wins over the clear
      arm_q  <= 1'b0;
    end else begin
      if (set_i)           flag_q <= 1'b1;
      if (arm_i && flag_q) arm_q  <= 1'b1;
    end
  end
  assign flag_o = flag_q;

  assert_arm_implies_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> flag_q);
  assert_clear_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(arm_q) && $past(clr_i)));
endmodule

// File: rtl/tmr_pair_buf.sv
module tmr_pair_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_rd_i,
  input  logic              lo_rd_i,
  input  logic [DATA_W-1:0] lo_live_i,
  output logic [DATA_W-1:0] lo_o
);
  logic              held_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      lo_q   <= '0;
    end else if (hi_rd_i) begin
      held_q <= 1'b1;
      lo_q   <= lo_live_i;
    end else if (lo_rd_i) begin
      held_q <= 1'b0;
    end
  end

  assign lo_o = held_q ? lo_q : lo_live_i;

  assert_hold_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !hi_rd_i && $past(held_q)) |-> $stable(lo_q));
endmodule

// File: rtl/timer16_cc.sv
module timer16_cc
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [2*DATA_W-1:0] CNT_RST = 16'hFFFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              cap_pin_i,
  input  logic              cap_aux_i,
  output logic              cmp_pin_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic rd_stb, wr_stb;
  assign rd_stb = bus_en_i && !bus_we_i;
  assign wr_stb = bus_en_i &&  bus_we_i;

  // control register
  logic [NUM_FLAGS-1:0] ie_q;
  logic                 edge_q, lvl_q;
  logic                 ctrl_wr;
  logic                 unused_wdata;
  assign ctrl_wr      = wr_stb && (bus_addr_i == A_CTRL);
  assign unused_wdata = ^bus_wdata_i[DATA_W-NUM_FLAGS-1:CTRL_EDGE_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= '0;
      lvl_q <= 1'b0;
    end else if (ctrl_wr) begin
      for (int i = 0; i < NUM_FLAGS; i++) ie_q[i] <= bus_wdata_i[DATA_W-1-i];
      lvl_q <= bus_wdata_i[CTRL_LVL_BIT];
    end
  end

  // edge select survives reset by design
  always_ff @(posedge clk_i) begin
    if (ctrl_wr) edge_q <= bus_wdata_i[CTRL_EDGE_BIT];
  end

  // datapath
  logic [CNT_W-1:0] cnt, cnt_next, cap, cmp;
  logic             wrap, cap_evt, match;

  tmr_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .cnt_o(cnt), .cnt_next_o(cnt_next), .wrap_o(wrap)
  );

  tmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i, .rst_ni, .pin_i(cap_pin_i), .aux_i(cap_aux_i),
    .rise_sel_i(edge_q), .cnt_i(cnt), .evt_o(cap_evt), .cap_o(cap)
  );

  tmr_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk_i, .rst_ni,
    .wr_hi_i(wr_stb && (bus_addr_i == A_CMP_HI)),
    .wr_lo_i(wr_stb && (bus_addr_i == A_CMP_LO)),
    .wdata_i(bus_wdata_i), .tick_i, .cnt_next_i(cnt_next),
    .level_i(lvl_q), .cmp_o(cmp), .match_o(match), .pin_o(cmp_pin_o)
  );

  // flags
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;
  logic                 stat_rd;
  assign stat_rd         = rd_stb && (bus_addr_i == A_STAT);
  assign flag_set[F_CAP] = cap_evt;
  assign flag_set[F_CMP] = match;
  assign flag_set[F_OVF] = wrap;
  assign flag_clr[F_CAP] = rd_stb && (bus_addr_i == A_CAP_LO);
  assign flag_clr[F_CMP] = wr_stb && (bus_addr_i == A_CMP_LO);
  assign flag_clr[F_OVF] = rd_stb && (bus_addr_i == A_CNT_LO);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tmr_flag u_flag (
      .clk_i, .rst_ni, .set_i(flag_set[g]), .arm_i(stat_rd),
      .clr_i(flag_clr[g]), .flag_o(flags[g])
    );
  end

  assign irq_o = |(flags & ie_q);

  // coherent low-byte readers
  logic [NUM_PAIRS-1:0]    pair_hi_rd, pair_lo_rd;
  logic [DATA_W-1:0]       pair_live [NUM_PAIRS];
  logic [DATA_W-1:0]       pair_lo   [NUM_PAIRS];
  assign pair_hi_rd[P_CNT] = rd_stb && (bus_addr_i == A_CNT_HI);
  assign pair_lo_rd[P_CNT] = rd_stb && (bus_addr_i == A_CNT_LO);
  assign pair_hi_rd[P_CAP] = rd_stb && (bus_addr_i == A_CAP_HI);
  assign pair_lo_rd[P_CAP] = rd_stb && (bus_addr_i == A_CAP_LO);
  assign pair_live[P_CNT]  = cnt[DATA_W-1:0];
  assign pair_live[P_CAP]  = cap[DATA_W-1:0];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    tmr_pair_buf #(.DATA_W(DATA_W)) u_buf (
      .clk_i, .rst_ni, .hi_rd_i(pair_hi_rd[p]), .lo_rd_i(pair_lo_rd[p]),
      .lo_live_i(pair_live[p]), .lo_o(pair_lo[p])
    );
  end

  // read mux
  logic [DATA_W-1:0] ctrl_rd, stat_rdata;
  always_comb begin
    ctrl_rd    = '0;
    stat_rdata = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      ctrl_rd[DATA_W-1-i]    = ie_q[i];
      stat_rdata[DATA_W-1-i] = flags[i];
    end
    ctrl_rd[CTRL_EDGE_BIT] = edge_q;
    ctrl_rd[CTRL_LVL_BIT]  = lvl_q;
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:   bus_rdata_o = ctrl_rd;
      A_STAT:   bus_rdata_o = stat_rdata;
      A_CNT_HI: bus_rdata_o = cnt[CNT_W-1:DATA_W];
      A_CNT_LO: bus_rdata_o = pair_lo[P_CNT];
      A_CAP_HI: bus_rdata_o = cap[CNT_W-1:DATA_W];
      A_CAP_LO: bus_rdata_o = pair_lo[P_CAP];
      A_CMP_HI: bus_rdata_o = cmp[CNT_W-1:DATA_W];
      default:  bus_rdata_o = cmp[DATA_W-1:0];
    endcase
  end

  assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != '0));
  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
  assert_ovf_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wrap)) |-> flags[F_OVF]);
endmodule

// File: tb/timer16_cc_test.sv
`timescale 1ns/1ps
module timer16_cc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       en = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cap_pin = 1'b0, cap_aux = 1'b0;
  logic       cmp_pin, irq;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, CNTH = 3'd2, CNTL = 3'd3,
                         CAPH = 3'd4, CAPL = 3'd5, CMPH = 3'd6, CMPL = 3'd7;

  // {write value, expected readback} for control register
  localparam logic [15:0] CTRL_VEC [6] = '{
    16'hFF_E3, 16'h1C_00, 16'hA2_A2, 16'h41_41, 16'h23_23, 16'h00_00 };

  always #10 clk = ~clk;

  timer16_cc uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cap_pin_i(cap_pin), .cap_aux_i(cap_aux),
    .cmp_pin_o(cmp_pin), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); en = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] h, l, s;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(CTRL, s); check("R1 ctrl after reset", {8'h0, s & 8'hFD}, 16'h0000);
    peek(STAT, s); check("R1 status after reset", {8'h0, s}, 16'h0000);
    rd(CNTH, h); rd(CNTL, l); check("R1 counter after reset", {h, l}, 16'hFFFC);
    check("R1 cmp pin / irq after reset", {15'h0, cmp_pin | irq}, 16'h0000);

    // R3 control register vectors
    for (int i = 0; i < 6; i++) begin
      wr(CTRL, CTRL_VEC[i][15:8]);
      rd(CTRL, s);
      check("R3 ctrl readback", {8'h0, s}, {8'h0, CTRL_VEC[i][7:0]});
    end

    wr(CMPH, 8'h80); wr(CMPL, 8'h00);
    rd(CMPH, h); rd(CMPL, l); check("R3 compare readback", {h, l}, 16'h8000);

    // R2 counting and overflow
    ticks(3);
    rd(CNTH, h); rd(CNTL, l); check("R2 count FFFF", {h, l}, 16'hFFFF);
    peek(STAT, s); check("R2 no ovf before wrap", {15'h0, s[5]}, 16'h0000);
    idle(4);
    rd(CNTH, h); rd(CNTL, l); check("R2 count held without tick", {h, l}, 16'hFFFF);
    ticks(1);
    peek(STAT, s); check("R2 ovf flag on wrap", {8'h0, s}, 16'h0020);

    // R10 interrupt gating
    check("R10 irq low when masked", {15'h0, irq}, 16'h0000);
    wr(CTRL, 8'h20); #1 check("R10 irq on ovf+enable", {15'h0, irq}, 16'h0001);
    wr(CTRL, 8'hC0); #1 check("R10 irq low other enables", {15'h0, irq}, 16'h0000);
    wr(CTRL, 8'h00);

    // R9 overflow clear handshake
    rd(CNTL, l);
    peek(STAT, s); check("R9 unarmed cnt_lo read keeps ovf", {15'h0, s[5]}, 16'h0001);
    rd(STAT, s);
    rd(CNTL, l);
    peek(STAT, s); check("R9 armed cnt_lo read clears ovf", {15'h0, s[5]}, 16'h0000);

    // R11 coherent counter read
    rd(CNTH, h);
    ticks(5);
    rd(CNTL, l); check("R11 held low byte", {h, l}, 16'h0000);
    rd(CNTL, l); check("R11 live low byte after", {8'h0, l}, 16'h0005);

    // R6 compare match
    wr(CTRL, 8'h01);
    wr(CMPH, 8'h00); wr(CMPL, 8'h10);
    ticks(10);
    peek(STAT, s);
    check("R6 no match before value", {7'h0, cmp_pin, s}, 16'h0000);
    ticks(1);
    peek(STAT, s);
    check("R6 match sets flag and pin", {7'h0, cmp_pin, s}, 16'h0140);

    // R8 compare clear handshake
    wr(CMPL, 8'h10);
    peek(STAT, s); check("R8 unarmed cmp_lo write keeps flag", {15'h0, s[6]}, 16'h0001);
    rd(STAT, s);
    wr(CMPL, 8'h10);
    peek(STAT, s); check("R8 armed cmp_lo write clears flag", {8'h0, s}, 16'h0000);

    // R7 high-byte write inhibits
    wr(CTRL, 8'h00);
    wr(CMPL, 8'h18); wr(CMPH, 8'h00);
    ticks(8);
    rd(CNTH, h); rd(CNTL, l); check("R7 counter at target", {h, l}, 16'h0018);
    peek(STAT, s);
    check("R7 inhibited: no flag, pin kept", {7'h0, cmp_pin, s}, 16'h0100);
    wr(CMPL, 8'h1A);
    ticks(2);
    peek(STAT, s);
    check("R7 released: match resumes", {7'h0, cmp_pin, s}, 16'h0040);
    rd(STAT, s); wr(CMPL, 8'h1A);

    // R4 rising-edge pin capture, three-edge latency
    wr(CTRL, 8'h82);
    @(negedge clk); cap_pin = 1'b1; addr = STAT;
    @(negedge clk); #1 check("R4 no capture after edge 1", {15'h0, rdata[7]}, 16'h0000);
    @(negedge clk); #1 check("R4 no capture after edge 2", {15'h0, rdata[7]}, 16'h0000);
    @(negedge clk); #1 check("R4 capture after edge 3", {15'h0, rdata[7]}, 16'h0001);
    check("R10 irq on capture+enable", {15'h0, irq}, 16'h0001);
    rd(CAPH, h); rd(CAPL, l); check("R4 capture value", {h, l}, 16'h001A);
    rd(STAT, s); rd(CAPL, l);
    peek(STAT, s); check("R9 armed cap_lo read clears capture", {15'h0, s[7]}, 16'h0000);
    @(negedge clk); cap_pin = 1'b0;
    idle(5);
    peek(STAT, s); check("R4 falling edge ignored when rising", {15'h0, s[7]}, 16'h0000);

    // R4 falling-edge select
    wr(CTRL, 8'h80);
    ticks(3);
    @(negedge clk); cap_pin = 1'b1;
    idle(5);
    peek(STAT, s); check("R4 rising edge ignored when falling", {15'h0, s[7]}, 16'h0000);
    @(negedge clk); cap_pin = 1'b0;
    idle(3);
    peek(STAT, s); check("R4 falling edge captures", {15'h0, s[7]}, 16'h0001);
    rd(CAPL, l);
    peek(STAT, s); check("R9 unarmed cap_lo read keeps flag", {15'h0, s[7]}, 16'h0001);
    rd(CAPH, h); rd(CAPL, l); check("R4 falling capture value", {h, l}, 16'h001D);
    rd(STAT, s); rd(CAPL, l);

    // R5 comparator strobe
    ticks(2);
    @(negedge clk); cap_aux = 1'b1;
    @(negedge clk); cap_aux = 1'b0;
    peek(STAT, s); check("R5 aux strobe sets capture flag", {15'h0, s[7]}, 16'h0001);
    rd(CAPH, h); rd(CAPL, l); check("R5 aux capture value", {h, l}, 16'h001F);

    // R12 coherent capture read across a new capture
    rd(CAPH, h);
    ticks(6);
    @(negedge clk); cap_aux = 1'b1;
    @(negedge clk); cap_aux = 1'b0;
    rd(CAPL, l); check("R12 held capture low byte", {h, l}, 16'h001F);
    rd(CAPH, h); rd(CAPL, l); check("R12 new capture after", {h, l}, 16'h0025);

    // R1 edge-select bit survives reset
    wr(CTRL, 8'hE3);
    do_reset();
    rd(CTRL, s); check("R1 edge bit kept (set)", {8'h0, s}, 16'h0002);
    wr(CTRL, 8'hE1);
    do_reset();
    rd(CTRL, s); check("R1 edge bit kept (clear)", {8'h0, s}, 16'h0000);
    rd(CNTH, h); rd(CNTL, l); check("R1 counter reload", {h, l}, 16'hFFFC);
    peek(STAT, s); check("R1 status cleared", {8'h0, s}, 16'h0000);

    finish_run();
  end
endmodule